// File: doc/BRIEF.md
# Serial Digitizer Command and Conversion Sequencer

This block is the device-side serial front end of a successive-approximation digitizer. The digitizer takes its serial clock from the host. The block oversamples the host's serial clock, chip select and data input on its own system clock. It looks for a start bit on the data input, then collects the rest of an eight-bit command one bit per serial-clock rising edge. From the command it takes the channel address, the resolution, the reference selection and the two power-management bits.

After the command it steps through a three-clock sampling window and a one-clock busy pulse, then returns the converted value MSB first, one bit per serial-clock falling edge. A behavioural input, `conv_value`, takes the place of the analog converter core. A host that keeps chip select low can send the next command while the previous result is still shifting out, which gives 15-clock frames for 12-bit results and 11-clock frames for 8-bit results. Raising chip select releases the outputs and abandons any conversion in progress.

Top module: `adc_serial_seq`

## Requirements
- R1: While no command is in progress, low bits on `din` are ignored: `busy`, `sampling` and `dout` stay low until a high bit is sampled on a serial-clock rising edge, and that edge counts as rising edge 1 of the command.
- R2: Rising edges 2 to 8 carry address bits 2, 1, 0, then the resolution bit, the reference-select bit and power bits 1, 0. `pd_mode` takes the two power bits at rising edge 8 and keeps its old value before that edge.
- R3: `sampling` goes high at falling edge 5 and low at falling edge 8, so it lasts three serial clocks.
- R4: `busy` goes high at falling edge 8 and low at falling edge 9.
- R5: `dout` is low while the command is clocked in. The result MSB appears at falling edge 9, each later falling edge moves out the next bit, and zeros follow the last result bit.
- R6: Resolution bit 0 returns all 12 bits of `conv_value`. Resolution bit 1 returns only its upper 8 bits and then zeros.
- R7: `conv_value` is captured at falling edge 8. A later change does not alter the result being shifted out.
- R8: With chip select held low, a high `din` is taken as a new start bit at rising edge 16 or later after a 12-bit command, or at rising edge 12 or later after an 8-bit command. A high bit before that edge is ignored, and the earlier result keeps shifting out alongside the new command.
- R9: While `cs_n` is high, `dout_oe` and `busy_oe` are low, `busy`, `sampling` and `dout` are forced low, `din` is ignored, `pd_mode` is unchanged, and no conversion resumes once `cs_n` falls again.
- R10: Address 000 with reference-select 1 returns the fixed code 1000 0000 0000 whatever `conv_value` is. Address 000 with reference-select 0 returns `conv_value`.
- R11: After reset, `dout`, `busy`, `sampling`, `dout_oe`, `busy_oe` and `pd_mode` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock used to oversample the serial pins |
| rst_n | input | 1 | Active-low asynchronous reset |
| dclk | input | 1 | Serial and conversion clock from the host |
| cs_n | input | 1 | Active-low chip select |
| din | input | 1 | Serial command input |
| conv_value | input | 12 | Behavioural converter value standing in for the analog core |
| dout | output | 1 | Serial result output |
| dout_oe | output | 1 | Output enable for `dout` |
| busy | output | 1 | Conversion-busy flag |
| busy_oe | output | 1 | Output enable for `busy` |
| sampling | output | 1 | High during the three-clock sampling window |
| pd_mode | output | 2 | Power-management bits of the last complete command |

## Verification
Every pin passes through two synchronizer flops and one state register, so each output changes on the third system-clock edge after the serial-clock edge that causes it. The bench keeps each serial-clock phase at eight system clocks. It reads the outputs 35 ns after each falling edge, which is after they have settled and before the next rising edge. Each reading is stored under the number of the falling edge it follows. Results that fall due at falling edges 5, 8 and 9, and the shifted bits after them, are compared at exactly those indices. `pd_mode` is read both after falling edge 7 and after falling edge 8, which brackets the rising edge where it is due to change.

// File: rtl/adc_seq_pkg.sv
`timescale 1ns/1ps
package adc_seq_pkg;
  localparam int RES_W  = 12;
  localparam int LOW_W  = 8;
  localparam int WORD_W = 8;
  localparam int ADDR_W = 3;
  localparam int PD_W   = 2;

  localparam logic [RES_W-1:0]  ID_CODE = RES_W'(1) << (RES_W - 1);
  localparam logic [ADDR_W-1:0] ID_ADDR = '0;

  // command fields after the start bit, first received bit at the top
  typedef struct packed {
    logic [ADDR_W-1:0] addr;
    logic              low_res;
    logic              single;
    logic [PD_W-1:0]   pd;
  } cfg_t;

  // result word as it is shifted out, MSB first, zero padded
  function automatic logic [RES_W-1:0] shape_result(input cfg_t c,
                                                    input logic [RES_W-1:0] raw);
    if (c.addr == ID_ADDR && c.single) return ID_CODE;
    if (c.low_res) return {raw[RES_W-1 -: LOW_W], {(RES_W-LOW_W){1'b0}}};
    return raw;
  endfunction
endpackage

// File: rtl/adc_seq_sync.sv
`timescale 1ns/1ps
module adc_seq_sync #(
  parameter int           W       = 3,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] a,
  output logic [W-1:0] q
);
  for (genvar b = 0; b < W; b++) begin : g_bit
    logic s1, s2;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        s1 <= RST_VAL[b];
        s2 <= RST_VAL[b];
      end else begin
        s1 <= a[b];
        s2 <= s1;
      end
    end
    assign q[b] = s2;
  end
endmodule

// File: rtl/adc_seq_ctrl.sv
`timescale 1ns/1ps
module adc_seq_ctrl
  import adc_seq_pkg::*;
#(
  parameter int CNT_W    = 5,
  parameter int ACQ_FALL = 5,
  parameter int ACQ_CYC  = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             dclk_s,
  input  logic             din_s,
  input  logic             cs_hi,
  input  logic [RES_W-1:0] conv_value,
  output cfg_t             cfg,
  output logic             sampling,
  output logic             busy,
  output logic             fall_ev,
  output logic             ev_out,
  output logic [RES_W-1:0] held
);
  localparam int HOLD_FALL = ACQ_FALL + ACQ_CYC;
  localparam int OUT_FALL  = HOLD_FALL + 1;
  localparam int NEXT_HI   = RES_W + ACQ_CYC + 1;
  localparam int NEXT_LO   = LOW_W + ACQ_CYC + 1;
  localparam logic [CNT_W-1:0] CNT_MAX = '1;

  logic             dclk_d;
  logic             active;
  logic [CNT_W-1:0] cnt;
  logic [WORD_W-3:0] word_sr;
  logic [WORD_W-2:0] next_word;
  logic rise_ev, hunting, ev_start, ev_bit, ev_word, fall_live, ev_acq, ev_hold;

  assign rise_ev   = dclk_s & ~dclk_d;
  assign fall_ev   = ~dclk_s & dclk_d;
  assign hunting   = !active ||
                     cnt >= (cfg.low_res ? CNT_W'(NEXT_LO - 1) : CNT_W'(NEXT_HI - 1));
  assign ev_start  = rise_ev & ~cs_hi & hunting & din_s;
  assign ev_bit    = rise_ev & ~cs_hi & active & ~ev_start & (cnt < CNT_W'(WORD_W));
  assign ev_word   = ev_bit & (cnt == CNT_W'(WORD_W - 1));
  assign next_word = {word_sr, din_s};
  assign fall_live = fall_ev & ~cs_hi & active;
  assign ev_acq    = fall_live & (cnt == CNT_W'(ACQ_FALL));
  assign ev_hold   = fall_live & (cnt == CNT_W'(HOLD_FALL));
  assign ev_out    = fall_live & (cnt == CNT_W'(OUT_FALL));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dclk_d   <= 1'b0;
      active   <= 1'b0;
      cnt      <= '0;
      word_sr  <= '0;
      cfg      <= '0;
      sampling <= 1'b0;
      busy     <= 1'b0;
      held     <= '0;
    end else begin
      dclk_d <= dclk_s;
      if (cs_hi) begin
        active   <= 1'b0;
        cnt      <= '0;
        sampling <= 1'b0;
        busy     <= 1'b0;
      end else begin
        if (ev_start) begin
          active <= 1'b1;
          cnt    <= CNT_W'(1);
        end else if (rise_ev && active && cnt != CNT_MAX) begin
          cnt <= cnt + 1'b1;
        end
        if (ev_bit)  word_sr <= next_word[WORD_W-3:0];
        if (ev_word) cfg     <= cfg_t'(next_word);
        if (ev_acq)  sampling <= 1'b1;
        if (ev_hold) begin
          sampling <= 1'b0;
          busy     <= 1'b1;
          held     <= shape_result(cfg, conv_value);
        end
        if (ev_out) busy <= 1'b0;
      end
    end
  end

  // R4: busy only starts as the sampling window closes
  p_busy_after_sampling_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> $past(sampling));
  // R3: sampling and busy never overlap
  p_sample_busy_excl_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !(sampling && busy));
  // R2: command fields change only on a serial rising edge
  p_cfg_on_rise_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !rise_ev |=> $stable(cfg));
  // R9: deselect clears the conversion phases
  p_abort_r9: assert property (@(posedge clk) disable iff (!rst_n)
    cs_hi |=> (!busy && !sampling));
endmodule

// File: rtl/adc_seq_shift.sv
`timescale 1ns/1ps
module adc_seq_shift
  import adc_seq_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             abort,
  input  logic             load,
  input  logic             shift,
  input  logic [RES_W-1:0] load_value,
  output logic             dout
);
  logic [RES_W-1:0] shreg;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     shreg <= '0;
    else if (abort) shreg <= '0;
    else if (load)  shreg <= load_value;
    else if (shift) shreg <= {shreg[RES_W-2:0], 1'b0};
  end

  assign dout = shreg[RES_W-1];

  // R5: the output bit moves only on a falling edge, a load or an abort
  p_dout_quiet_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !(abort || load || shift) |=> $stable(dout));
endmodule

// File: rtl/adc_serial_seq.sv
`timescale 1ns/1ps
module adc_serial_seq #(
  parameter int CNT_W    = 5,
  parameter int ACQ_FALL = 5,
  parameter int ACQ_CYC  = 3
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        dclk,
  input  logic        cs_n,
  input  logic        din,
  input  logic [11:0] conv_value,
  output logic        dout,
  output logic        dout_oe,
  output logic        busy,
  output logic        busy_oe,
  output logic        sampling,
  output logic [1:0]  pd_mode
);
  import adc_seq_pkg::*;

  logic [2:0]       pins_s;
  logic             cs_hi, dclk_s, din_s;
  logic             fall_ev, ev_out;
  logic [RES_W-1:0] held;
  cfg_t             cfg;

  adc_seq_sync #(.W(3), .RST_VAL(3'b100)) u_sync (
    .clk(clk), .rst_n(rst_n), .a({cs_n, dclk, din}), .q(pins_s));

  assign cs_hi  = pins_s[2];
  assign dclk_s = pins_s[1];
  assign din_s  = pins_s[0];

  adc_seq_ctrl #(.CNT_W(CNT_W), .ACQ_FALL(ACQ_FALL), .ACQ_CYC(ACQ_CYC)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .dclk_s(dclk_s), .din_s(din_s), .cs_hi(cs_hi),
    .conv_value(conv_value), .cfg(cfg), .sampling(sampling), .busy(busy),
    .fall_ev(fall_ev), .ev_out(ev_out), .held(held));

  adc_seq_shift u_shift (
    .clk(clk), .rst_n(rst_n), .abort(cs_hi), .load(ev_out), .shift(fall_ev),
    .load_value(held), .dout(dout));

  assign dout_oe = ~cs_hi;
  assign busy_oe = ~cs_hi;
  assign pd_mode = cfg.pd;
endmodule

// File: tb/adc_serial_seq_bench.sv
`timescale 1ns/1ps
module adc_serial_seq_bench;
  logic clk = 1'b0, rst_n = 1'b0, dclk = 1'b0, cs_n = 1'b1, din = 1'b0;
  logic [11:0] conv = '0;
  logic dout, dout_oe, busy, busy_oe, sampling;
  logic [1:0] pd_mode;
  int n_chk = 0, n_bad = 0;
  logic dq [0:63];
  logic bq [0:63];
  logic sq [0:63];
  logic [1:0] pq [0:63];

  always #2.5 clk = ~clk;

  adc_serial_seq u_adc_serial_seq (
    .clk(clk), .rst_n(rst_n), .dclk(dclk), .cs_n(cs_n), .din(din),
    .conv_value(conv), .dout(dout), .dout_oe(dout_oe), .busy(busy),
    .busy_oe(busy_oe), .sampling(sampling), .pd_mode(pd_mode));

  task automatic chk(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // one serial clock per bit; outputs read 35 ns after each falling edge
  task automatic run(input logic [63:0] bits, input int n,
                     input int chg_at, input logic [11:0] chg_val);
    for (int i = 0; i < n; i++) begin
      din = bits[n-1-i];
      #40 dclk = 1'b1;
      #40 dclk = 1'b0;
      #35;
      dq[i] = dout; bq[i] = busy; sq[i] = sampling; pq[i] = pd_mode;
      if (i == chg_at) conv = chg_val;
      #5;
    end
  endtask

  task automatic chk_word(input string req, input int base, input logic [11:0] v, input int nb);
    for (int k = 0; k < nb; k++) chk(req, dq[base+k], v[11-k]);
  endtask

  task automatic t_reset;
    chk("R11 dout", dout, 0);       chk("R11 busy", busy, 0);
    chk("R11 dout_oe", dout_oe, 0); chk("R11 busy_oe", busy_oe, 0);
    chk("R11 sampling", sampling, 0); chk("R11 pd_mode", pd_mode, 0);
  endtask

  task automatic t_basic;
    cs_n = 1'b0; #100;
    chk("R9 oe on select", dout_oe & busy_oe, 1);
    conv = 12'hA5C;
    run({3'b000, 8'b1_001_0_0_11, 13'b0}, 24, 10, 12'h000);
    for (int i = 0; i < 3; i++) begin
      chk("R1 idle dout", dq[i], 0); chk("R1 idle busy", bq[i], 0); chk("R1 idle sampling", sq[i], 0);
    end
    chk("R3 before window", sq[6], 0);
    for (int i = 7; i < 10; i++) chk("R3 window", sq[i], 1);
    chk("R3 window end", sq[10], 0);
    chk("R4 pre", bq[9], 0); chk("R4 high", bq[10], 1); chk("R4 low", bq[11], 0);
    for (int i = 3; i < 11; i++) chk("R5 low during command", dq[i], 0);
    chk_word("R5 R7 result held", 11, 12'hA5C, 12);
    chk("R5 trailing zero", dq[23], 0);
    chk("R2 pd before edge 8", pq[9], 0); chk("R2 pd after edge 8", pq[10], 3);
  endtask

  task automatic t_low_res;
    conv = 12'h3C7;
    run({8'b1_010_1_0_00, 14'b0}, 22, -1, 12'h0);
    chk("R2 pd old value", pq[6], 3); chk("R2 pd new value", pq[7], 0);
    chk_word("R6 upper byte", 8, 12'h3C0, 12);
  endtask

  task automatic t_ident;
    conv = 12'h123;
    run({8'b1_000_0_1_01, 14'b0}, 22, -1, 12'h0);
    chk_word("R10 identity", 8, 12'h800, 12);
    run({8'b1_000_0_0_01, 14'b0}, 22, -1, 12'h0);
    chk_word("R10 addr 0 differential", 8, 12'h123, 12);
  endtask

  task automatic t_overlap12;
    conv = 12'h6B1;
    run({8'b1_001_0_0_11, 7'b0001000, 8'b1_101_0_0_10, 16'b0}, 39, 8, 12'h19E);
    chk_word("R8 first result", 8, 12'h6B1, 12);
    chk("R8 no early start busy", bq[14], 0);
    chk("R8 second busy", bq[22], 1);
    chk("R8 pd before", pq[21], 3); chk("R8 pd after", pq[22], 2);
    chk_word("R8 second result", 23, 12'h19E, 12);
  endtask

  task automatic t_overlap8;
    conv = 12'hE4D;
    run({8'b1_011_1_0_11, 3'b001, 8'b1_110_0_0_00, 16'b0}, 35, 8, 12'h5A2);
    chk_word("R6 R8 first byte", 8, 12'hE40, 8);
    for (int i = 16; i < 19; i++) chk("R6 trailing zeros", dq[i], 0);
    chk("R8 second busy", bq[18], 1);
    chk_word("R8 second result", 19, 12'h5A2, 12);
  endtask

  task automatic t_abort;
    conv = 12'hFFF;
    run({8'b1_001_0_0_00}, 8, -1, 12'h0);
    chk("R9 busy before abort", bq[7], 1);
    cs_n = 1'b1; #100;
    chk("R9 busy", busy, 0); chk("R9 busy_oe", busy_oe, 0);
    chk("R9 dout_oe", dout_oe, 0); chk("R9 dout", dout, 0); chk("R9 sampling", sampling, 0);
    run({8'b1_001_0_0_01, 4'b0}, 12, -1, 12'h0);
    for (int i = 0; i < 12; i++) begin
      chk("R9 ignored busy", bq[i], 0); chk("R9 ignored dout", dq[i], 0);
    end
    chk("R9 pd unchanged", pq[11], 0);
    cs_n = 1'b0; #100;
    run(64'b0, 12, -1, 12'h0);
    for (int i = 0; i < 12; i++) begin
      chk("R9 no resume busy", bq[i], 0); chk("R9 no resume dout", dq[i], 0);
    end
    conv = 12'h5A5;
    run({8'b1_001_0_0_00, 12'b0}, 20, -1, 12'h0);
    chk_word("R1 R9 fresh command", 8, 12'h5A5, 12);
  endtask

  initial begin
    #200_000;
    n_chk++; n_bad++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

  initial begin
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    #20;
    t_reset;
    t_basic;
    t_low_res;
    t_ident;
    t_overlap12;
    t_overlap8;
    t_abort;
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule